// File: doc/BRIEF.md
# PWM Phase Timebase

This block is the common time reference for a multi-channel pulse-width modulator. A programmable divider turns the input clock into a slower tick, the beat. Each beat advances a 16-bit phase value that stands for a fraction of one PWM cycle. Channel logic downstream compares its duty and delay settings against this phase.

The cycle length is set on a logarithmic scale. With resolution value `res`, one PWM cycle holds 2^(res+1) beats. The phase step per beat is scaled to match, so the phase always covers the whole 16-bit range once per cycle. Only the top res+1 phase bits ever change. A one-clock strobe marks the beat on which the phase wraps back to zero, which is the start of a new cycle.

Dropping the enable holds the whole timebase at zero. Raising it again starts a fresh cycle from phase zero with a full beat period.

Top module: `pwm_timebase`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and on the first clock after it, `phase` is 0 and `cycle_start` is 0.
- R2: A clock edge with `cntr_en` low leaves `phase` at 0 and `cycle_start` at 0 after it, and clears the internal divider count.
- R3: With `cntr_en` high, a beat occurs on every (`clk_div`+1)-th clock edge, counted from the edge after enabling. `phase` changes only on a beat.
- R4: On each beat `phase` increases by 2^(15-`res`) modulo 2^16, so a cycle lasts 2^(`res`+1)·(`clk_div`+1) clocks.
- R5: `cycle_start` is high for exactly one clock following the beat on which `phase` wraps through 2^16 to 0. That happens once every 2^(`res`+1) beats and never on two consecutive clocks. While it is high, `phase` is below 0x8000.
- R6: If `clk_div` is lowered below the divider's current count, the very next enabled clock edge is a beat.
- R7: After a disable, re-enabling restarts at phase 0, and the first beat comes a full (`clk_div`+1) clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntr_en | input | 1 | Counter enable; low clears and holds the timebase |
| clk_div | input | 27 | Beat period minus one, in input clocks |
| res | input | 4 | Logarithmic resolution; cycle is 2^(res+1) beats |
| phase | output | 16 | Current phase as a fraction of a PWM cycle |
| cycle_start | output | 1 | One-clock strobe at the start of each PWM cycle |

## Verification
The embedded assertions check on every clock the properties that hold cycle by cycle:
- zeroing while disabled;
- phase held between beats;
- phase moving on each beat;
- the strobe being isolated and occurring only at a low phase.

The exact beat spacing for a given divider, the step size chosen by the resolution, and the strobe landing once per 2^(res+1) beats are not visible in any single cycle. They are shown by the bench, which compares every clock against a beat-counting model. Directed scenarios also cover lowering the divider mid-count and re-enabling.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DIV_W = 27,
  parameter int RES_W = 4,
  parameter int PH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntr_en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [RES_W-1:0] res,
  output logic [PH_W-1:0]  phase,
  output logic             cycle_start
);

  localparam logic [RES_W-1:0] TOP = RES_W'(PH_W - 1);
  localparam logic [PH_W-1:0]  ONE = PH_W'(1);

  logic [DIV_W-1:0] div_cnt;
  logic [PH_W-1:0]  step;
  logic [PH_W:0]    sum;
  logic             beat;

  // ">=" so a divider lowered mid-count yields an immediate beat
  assign beat = div_cnt >= clk_div;
  assign step = ONE << (TOP - res);
  assign sum  = {1'b0, phase} + {1'b0, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt     <= '0;
      phase       <= '0;
      cycle_start <= 1'b0;
    end else if (!cntr_en) begin
      div_cnt     <= '0;
      phase       <= '0;
      cycle_start <= 1'b0;
    end else if (beat) begin
      div_cnt     <= '0;
      phase       <= sum[PH_W-1:0];
      cycle_start <= sum[PH_W];
    end else begin
      div_cnt     <= div_cnt + 1'b1;
      cycle_start <= 1'b0;
    end
  end

  assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cntr_en |=> (phase == '0 && !cycle_start && div_cnt == '0));

  assert_hold_between_beats_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cntr_en && !beat) |=> $stable(phase));

  assert_moves_on_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cntr_en && beat) |=> phase != $past(phase));

  assert_strobe_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start);

  assert_strobe_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> phase < 16'h8000);

endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntr_en = 1'b0;
  logic [26:0] clk_div = 27'h8000;
  logic [3:0]  res = 4'd7;
  logic [15:0] phase;
  logic        cycle_start;

  int total = 0;
  int bad = 0;

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .cntr_en(cntr_en), .clk_div(clk_div),
    .res(res), .phase(phase), .cycle_start(cycle_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Beat-counting model: phase is beats * step, strobe when beat count hits a cycle multiple
  logic [31:0] m_cnt, m_beats;
  logic        m_strobe;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !cntr_en) begin
      m_cnt <= 0; m_beats <= 0; m_strobe <= 0;
    end else if (m_cnt >= 32'(clk_div)) begin
      m_cnt    <= 0;
      m_beats  <= m_beats + 1;
      m_strobe <= (((m_beats + 1) & ((32'd1 << (res + 1)) - 1)) == 0);
    end else begin
      m_cnt    <= m_cnt + 1;
      m_strobe <= 0;
    end
  end

  function automatic logic [15:0] exp_phase(input logic [31:0] beats, input logic [3:0] r);
    logic [31:0] p;
    p = beats << (15 - r);
    return p[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic cmp_model();
    check("R4 phase", 32'(phase), 32'(exp_phase(m_beats, res)));
    check("R5 strobe", 32'(cycle_start), 32'(m_strobe));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap;
    int last;
    void'($urandom(32'd4711));
    // R1
    @(negedge clk);
    check("R1 phase in reset", 32'(phase), 0);
    check("R1 strobe in reset", 32'(cycle_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 phase after reset", 32'(phase), 0);
    check("R1 strobe after reset", 32'(cycle_start), 0);

    // R4: res=0, clk_div=0 alternates 0x8000 / 0
    res = 4'd0; clk_div = 27'd0; cntr_en = 1'b1;
    @(negedge clk); check("R4 res0 first beat", 32'(phase), 32'h8000);
    check("R5 no strobe at half", 32'(cycle_start), 0);
    @(negedge clk); check("R4 res0 wrap", 32'(phase), 0);
    check("R5 strobe on wrap", 32'(cycle_start), 1);
    @(negedge clk); check("R5 strobe one clock", 32'(cycle_start), 0);

    // R2: disable clears
    cntr_en = 1'b0;
    @(negedge clk); check("R2 phase cleared", 32'(phase), 0);
    check("R2 strobe low", 32'(cycle_start), 0);
    run(3);

    // R3/R5: res=0 clk_div=2 -> strobe spacing 6 clocks
    res = 4'd0; clk_div = 27'd2; cntr_en = 1'b1;
    last = -1; gap = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cmp_model();
      if (cycle_start) begin
        if (last >= 0) gap = i - last;
        last = i;
      end
    end
    check("R3 strobe spacing", 32'(gap), 6);

    // R7: re-enable starts from 0 with full beat period
    cntr_en = 1'b0; @(negedge clk);
    res = 4'd3; clk_div = 27'd3; cntr_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R7 no early beat", 32'(phase), 0);
    end
    @(negedge clk); check("R7 first beat", 32'(phase), 32'h1000);

    // R6: lower clk_div mid-count -> next edge is a beat
    cntr_en = 1'b0; @(negedge clk);
    res = 4'd3; clk_div = 27'd9; cntr_en = 1'b1;
    run(5);
    clk_div = 27'd1;
    @(negedge clk); check("R6 immediate beat", 32'(phase), 32'h1000);
    cmp_model();

    // Random segments
    for (int s = 0; s < 60; s++) begin
      cntr_en = 1'b0;
      @(negedge clk);
      check("R2 cleared between segments", 32'(phase), 0);
      res = 4'($urandom_range(0, 4));
      if (s == 7) res = 4'd15;
      clk_div = 27'($urandom_range(0, 5));
      cntr_en = 1'b1;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        cmp_model();
        if ($urandom_range(0, 40) == 0) clk_div = 27'($urandom_range(0, 5));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule